// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The block collects twenty interrupt requests and delivers the most urgent one to a single processor. Sources 0 to 15 come from outside the chip and sources 16 to 19 from internal units; all of them enter on the `irqIn` vector. Each source has its own configuration word, which holds a mask, a trigger mode, an active level or edge, a 4-bit priority and an 8-bit vector number. A source is offered to the processor when it is requesting, unmasked and not already in service. Its priority must also beat both the current task priority and the priority of the highest source already in service.

Software works through a 32-bit register port. A read of the acknowledge register returns the vector of the winning source and moves that source into service. A write to the end-of-interrupt register retires the highest-priority source in service, which lets interrupts nest. A global configuration register holds a self-timed soft reset and the enable for delivery.

Word addresses: global configuration 0x00, current task priority 0x04, acknowledge 0x08, end of interrupt 0x0C, and the configuration word of source i at 0x40 + 4*i.

Top module: `prio_vec_intc`

## Requirements
- R1: After `rstN` is released, every source reads 0x8000_0000 (masked, all fields zero), the task priority reads 15, the global word reads 0, `irqOut` is 0 and the acknowledge register reads 0xFF.
- R2: A source word holds the mask in bit 31, a read-only activity flag in bit 30, the active polarity in bit 23, the sense in bit 22, the priority in bits 19:16 and the vector in bits 7:0. Other bits read 0. A write to an idle source is read back unchanged.
- R3: While a source's activity flag is set (the source is requesting or in service), writes to it change only the mask bit. Polarity, sense, priority and vector keep their values.
- R4: An acknowledge read returns the winning vector, marks that source in service and clears its latched edge.
- R5: When nothing can be delivered, an acknowledge read returns 0xFF and changes no state.
- R6: A write of any data to the end-of-interrupt register clears the in-service source of highest priority, with the lowest index winning a tie.
- R7: A source is delivered only if its priority is strictly greater than both the task priority and the highest in-service priority. Among equal priorities the lowest index wins.
- R8: Writing bit 31 of the global word restores every reset value for `RST_CYC` (default 4) cycles. During that time bit 31 reads 1 and writes are ignored.
- R9: Bit 29 of the global word enables delivery. While it is 0, `irqOut` stays low and an acknowledge read returns 0xFF.
- R10: With sense 1 a request is level-triggered: high-active when polarity is 1, low-active when polarity is 0. With sense 0 the request is latched on a rising edge (polarity 1) or a falling edge (polarity 0).
- R11: A set mask bit keeps a requesting source from being delivered.
- R12: `irqOut` is registered. It follows a change in the delivery condition one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational from the address) |
| irqIn | input | 20 | Request lines; bits 19:16 are the internal sources |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is nested service. A low-priority source must already be in service when a higher one preempts it. A third source must then be held back only because of the in-service threshold, and not because of the task priority. The bench gets there with a chain of level requests and acknowledge reads. It drops the preempting request before the end-of-interrupt write, so the held-back source shows up as the next winner. Edge latching is checked with one-cycle pulses and with transitions in the direction opposite to the programmed polarity.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SRC_N  = 20;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = $clog2(SRC_N);

  localparam logic [ADDR_W-1:0] ADR_GCFG = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_CTP  = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_ACK  = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_EOI  = 8'h0C;
  localparam logic [ADDR_W-1:0] ADR_SRC0 = 8'h40;
  localparam logic [VEC_W-1:0]  SPURIOUS = 8'hFF;

  typedef struct packed {
    logic             srcWr;
    logic             ackRd;
    logic             eoiWr;
    logic             clrAll;
    logic [IDX_W-1:0] idx;
  } vic_strobe_t;

  typedef struct packed {
    logic              mask;
    logic              pol;
    logic              sense;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  vic_strobe_t       strb,
  input  logic [31:0]       wdata,
  input  logic              mode,
  input  logic [PRIO_W-1:0] ctp,
  input  logic [SRC_N-1:0]  irqIn,
  output logic [31:0]       srcWord,
  output logic [VEC_W-1:0]  ackVec,
  output logic              irqOut
);
  localparam src_cfg_t CFG_RST = '{mask: 1'b1, default: '0};

  src_cfg_t          cfg [SRC_N];
  logic [SRC_N-1:0]  prevIn, edgeLat, inSvc, pend, act, trig;
  logic              bestValid, svcAny, deliver;
  logic [IDX_W-1:0]  bestIdx, svcIdx;
  logic [PRIO_W-1:0] bestPrio, svcPrio, thresh;
  logic              unusedBits;

  assign unusedBits = ^{wdata[30:24], wdata[21:20], wdata[15:8]};

  always_comb begin
    for (int i = 0; i < SRC_N; i++) begin
      trig[i] = cfg[i].pol ? (irqIn[i] & ~prevIn[i]) : (~irqIn[i] & prevIn[i]);
      pend[i] = cfg[i].sense ? (irqIn[i] == cfg[i].pol) : edgeLat[i];
      act[i]  = pend[i] | inSvc[i];
    end
  end

  // winner among deliverable candidates; strict > keeps the lowest index on ties
  always_comb begin
    bestValid = 1'b0; bestIdx = '0; bestPrio = '0;
    svcAny = 1'b0; svcIdx = '0; svcPrio = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (pend[i] && !cfg[i].mask && !inSvc[i] && (!bestValid || cfg[i].prio > bestPrio)) begin
        bestValid = 1'b1; bestIdx = IDX_W'(i); bestPrio = cfg[i].prio;
      end
      if (inSvc[i] && (!svcAny || cfg[i].prio > svcPrio)) begin
        svcAny = 1'b1; svcIdx = IDX_W'(i); svcPrio = cfg[i].prio;
      end
    end
    thresh  = (svcAny && svcPrio > ctp) ? svcPrio : ctp;
    deliver = mode && bestValid && (bestPrio > thresh);
    ackVec  = deliver ? cfg[bestIdx].vec : SPURIOUS;
  end

  always_comb begin
    srcWord = '0;
    if (int'(strb.idx) < SRC_N) begin
      srcWord[31]            = cfg[strb.idx].mask;
      srcWord[30]            = act[strb.idx];
      srcWord[23]            = cfg[strb.idx].pol;
      srcWord[22]            = cfg[strb.idx].sense;
      srcWord[16 +: PRIO_W]  = cfg[strb.idx].prio;
      srcWord[0 +: VEC_W]    = cfg[strb.idx].vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= irqIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      for (int i = 0; i < SRC_N; i++) cfg[i] <= CFG_RST;
      edgeLat <= '0;
      inSvc   <= '0;
      irqOut  <= 1'b0;
    end else begin
      irqOut <= deliver;
      for (int i = 0; i < SRC_N; i++) begin
        if (strb.srcWr && strb.idx == IDX_W'(i)) begin
          cfg[i].mask <= wdata[31];
          if (!act[i]) begin
            cfg[i].pol   <= wdata[23];
            cfg[i].sense <= wdata[22];
            cfg[i].prio  <= wdata[16 +: PRIO_W];
            cfg[i].vec   <= wdata[0 +: VEC_W];
          end
        end
        if (strb.ackRd && deliver && bestIdx == IDX_W'(i)) begin
          inSvc[i]   <= 1'b1;
          edgeLat[i] <= 1'b0;
        end else begin
          if (strb.eoiWr && svcAny && svcIdx == IDX_W'(i)) inSvc[i] <= 1'b0;
          if (cfg[i].sense)  edgeLat[i] <= 1'b0;
          else if (trig[i])  edgeLat[i] <= 1'b1;
        end
      end
    end
  end

  p_ack_isr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackRd && deliver && !strb.clrAll) |=> inSvc[$past(bestIdx)]);

  p_eoi_retire_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiWr && (|inSvc) && !strb.clrAll) |=> $countones(inSvc) == $past($countones(inSvc)) - 1);

  p_mode_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(mode));

  for (genvar g = 0; g < SRC_N; g++) begin : g_lock
    p_cfg_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.srcWr && strb.idx == IDX_W'(g) && act[g] && !strb.clrAll)
        |=> $stable({cfg[g].pol, cfg[g].sense, cfg[g].prio, cfg[g].vec}));
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int RST_CYC = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [31:0]       srcWord,
  input  logic [VEC_W-1:0]  ackVec,
  output logic [31:0]       busRdata,
  output vic_strobe_t       strb,
  output logic              mode,
  output logic [PRIO_W-1:0] ctp
);
  localparam int CNT_W = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0]  rstCnt;
  logic              busy, srcHit, wrOk, rdOk;
  logic [ADDR_W-1:0] srcOff;
  logic              unusedBits;

  assign unusedBits = ^{busWdata[30], busWdata[28:PRIO_W]};
  assign busy   = (rstCnt != '0);
  assign srcOff = busAddr - ADR_SRC0;
  assign srcHit = (busAddr >= ADR_SRC0) && (srcOff[1:0] == 2'b00)
                  && (int'(srcOff[ADDR_W-1:2]) < SRC_N);
  assign wrOk   = busSel && busWr && !busy;
  assign rdOk   = busSel && !busWr && !busy;

  always_comb begin
    strb.srcWr  = wrOk && srcHit;
    strb.eoiWr  = wrOk && busAddr == ADR_EOI;
    strb.ackRd  = rdOk && busAddr == ADR_ACK;
    strb.clrAll = busy;
    strb.idx    = srcOff[IDX_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstCnt <= '0;
      mode   <= 1'b0;
      ctp    <= '1;
    end else if (busy) begin
      rstCnt <= rstCnt - 1'b1;
      mode   <= 1'b0;
      ctp    <= '1;
    end else if (wrOk && busAddr == ADR_GCFG) begin
      if (busWdata[31]) begin
        rstCnt <= CNT_W'(RST_CYC);
        mode   <= 1'b0;
      end else begin
        mode   <= busWdata[29];
      end
    end else if (wrOk && busAddr == ADR_CTP) begin
      ctp <= busWdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADR_GCFG) begin
      busRdata[31] = busy;
      busRdata[29] = mode;
    end else if (busAddr == ADR_CTP) begin
      busRdata[PRIO_W-1:0] = ctp;
    end else if (busAddr == ADR_ACK) begin
      busRdata[VEC_W-1:0] = busy ? SPURIOUS : ackVec;
    end else if (srcHit) begin
      busRdata = srcWord;
    end
  end

  p_softrst_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (ctp == '1) && !mode);

  p_softrst_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && busAddr == ADR_GCFG && busWdata[31]) |=> busy);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import vic_pkg::*;
#(
  parameter int RST_CYC = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [SRC_N-1:0]  irqIn,
  output logic              irqOut
);
  vic_strobe_t       strb;
  logic              mode;
  logic [PRIO_W-1:0] ctp;
  logic [31:0]       srcWord;
  logic [VEC_W-1:0]  ackVec;

  vic_ctrl #(.RST_CYC(RST_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .srcWord(srcWord), .ackVec(ackVec), .busRdata(busRdata),
    .strb(strb), .mode(mode), .ctp(ctp)
  );

  vic_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .mode(mode), .ctp(ctp),
    .irqIn(irqIn), .srcWord(srcWord), .ackVec(ackVec), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
  localparam int RST_CYC = 4;
  localparam int NT = 10;
  // priority of source i is (i & 7) + 1, vector 0x40 + i, level high-active
  localparam logic [19:0] T_IN  [NT] = '{20'h00001, 20'h00003, 20'h08080, 20'h00008, 20'h00008,
                                         20'h80800, 20'h10101, 20'hFFFFF, 20'hFFFFF, 20'h40000};
  localparam logic [3:0]  T_CTP [NT] = '{4'd0, 4'd0, 4'd0, 4'd4, 4'd3, 4'd0, 4'd0, 4'd8, 4'd7, 4'd0};
  localparam logic [7:0]  T_EXP [NT] = '{8'h40, 8'h41, 8'h47, 8'hFF, 8'h43,
                                         8'h4B, 8'h40, 8'hFF, 8'h47, 8'h52};

  logic clk = 0, rstN = 0, busSel = 0, busWr = 0, irqOut;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, rd;
  logic [19:0] irqIn = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  prio_vec_intc #(.RST_CYC(RST_CYC)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  function automatic logic [31:0] sw(input logic m, p, s, input logic [3:0] pr, input logic [7:0] v);
    return {m, 7'b0, p, s, 2'b0, pr, 8'b0, v};
  endfunction
  function automatic logic [7:0] sa(input int i);
    return 8'h40 + 8'(4 * i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  task automatic idle2();
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irqOut", 32'(irqOut), 0);
    rdReg(8'h00, rd); chk("R1 gcfg", rd, 0);
    rdReg(8'h04, rd); chk("R1 ctp", rd, 15);
    rdReg(sa(0), rd); chk("R1 src0", rd, 32'h8000_0000);
    rdReg(8'h08, rd); chk("R1 ack", rd, 32'hFF);

    for (int i = 0; i < 20; i++) wr(sa(i), sw(0, 1, 1, 4'((i & 7) + 1), 8'h40 + 8'(i)));
    rdReg(sa(9), rd); chk("R2 readback", rd, sw(0, 1, 1, 2, 8'h49));
    wr(8'h04, 0);
    // R9 delivery disabled
    irqIn[0] = 1; idle2();
    chk("R9 irqOut off", 32'(irqOut), 0);
    rdReg(8'h08, rd); chk("R9 ack off", rd, 32'hFF);
    irqIn = '0;
    wr(8'h00, 32'h2000_0000);
    rdReg(8'h00, rd); chk("R9 gcfg", rd, 32'h2000_0000);

    // R12 registered output
    wr(8'h04, 15); irqIn[4] = 1; idle2();
    chk("R12 blocked", 32'(irqOut), 0);
    wr(8'h04, 0);
    chk("R12 same cycle", 32'(irqOut), 0);
    @(negedge clk);
    chk("R12 next cycle", 32'(irqOut), 1);
    rdReg(8'h08, rd); chk("R4 ack", rd, 32'h44);
    irqIn = '0; wr(8'h0C, 0);

    // table walk: R7 selection, R5 spurious leaves state untouched
    for (int t = 0; t < NT; t++) begin
      irqIn = T_IN[t];
      wr(8'h04, 32'(T_CTP[t]));
      idle2();
      chk("R7 irqOut", 32'(irqOut), (T_EXP[t] == 8'hFF) ? 0 : 1);
      rdReg(8'h08, rd); chk("R7 ack vector", rd, 32'(T_EXP[t]));
      irqIn = '0;
      if (T_EXP[t] != 8'hFF) wr(8'h0C, 32'hDEAD);
    end
    wr(8'h04, 0);

    // R6 nesting and in-service threshold
    irqIn[2] = 1; idle2();
    rdReg(8'h08, rd); chk("R4 low ack", rd, 32'h42);
    irqIn[7] = 1; idle2();
    chk("R7 preempt", 32'(irqOut), 1);
    rdReg(8'h08, rd); chk("R7 preempt ack", rd, 32'h47);
    irqIn[5] = 1; idle2();
    chk("R7 isr threshold", 32'(irqOut), 0);
    rdReg(8'h08, rd); chk("R7 isr ack", rd, 32'hFF);
    irqIn[7] = 0;
    wr(8'h0C, 32'h1234); idle2();
    rdReg(sa(7), rd); chk("R6 retired top", rd, sw(0, 1, 1, 8, 8'h47));
    rdReg(sa(2), rd); chk("R6 kept low", rd, sw(0, 1, 1, 3, 8'h42) | 32'h4000_0000);
    chk("R6 next pending", 32'(irqOut), 1);
    rdReg(8'h08, rd); chk("R6 next ack", rd, 32'h45);
    irqIn = '0;
    wr(8'h0C, 0); wr(8'h0C, 0);
    rdReg(sa(2), rd); chk("R6 all retired", rd, sw(0, 1, 1, 3, 8'h42));

    // R3 lock and R11 mask
    wr(8'h04, 15);
    irqIn[5] = 1; idle2();
    wr(sa(5), sw(0, 0, 0, 15, 8'h99));
    rdReg(sa(5), rd); chk("R3 refused", rd, sw(0, 1, 1, 6, 8'h45) | 32'h4000_0000);
    wr(sa(5), sw(1, 0, 0, 15, 8'h99));
    rdReg(sa(5), rd); chk("R3 mask only", rd, sw(1, 1, 1, 6, 8'h45) | 32'h4000_0000);
    wr(8'h04, 0); idle2();
    chk("R11 masked irqOut", 32'(irqOut), 0);
    rdReg(8'h08, rd); chk("R11 masked ack", rd, 32'hFF);
    irqIn = '0; idle2();
    wr(sa(5), sw(1, 0, 0, 9, 8'h55));
    rdReg(sa(5), rd); chk("R2 idle write", rd, sw(1, 0, 0, 9, 8'h55));

    // R10 edge and level modes
    wr(sa(12), sw(0, 1, 0, 10, 8'h4C));
    @(negedge clk); irqIn[12] = 1; @(negedge clk); irqIn[12] = 0;
    idle2();
    chk("R10 rising latched", 32'(irqOut), 1);
    rdReg(8'h08, rd); chk("R10 rising ack", rd, 32'h4C);
    wr(8'h0C, 0); idle2();
    rdReg(8'h08, rd); chk("R10 latch cleared", rd, 32'hFF);
    wr(sa(13), sw(0, 0, 0, 10, 8'h4D));
    irqIn[13] = 1; idle2();
    rdReg(8'h08, rd); chk("R10 wrong edge", rd, 32'hFF);
    irqIn[13] = 0; idle2();
    rdReg(8'h08, rd); chk("R10 falling ack", rd, 32'h4D);
    wr(8'h0C, 0);
    wr(sa(14), sw(0, 0, 1, 10, 8'h4E)); idle2();
    rdReg(8'h08, rd); chk("R10 low level", rd, 32'h4E);
    irqIn[14] = 1; wr(8'h0C, 0); idle2();
    rdReg(8'h08, rd); chk("R10 low released", rd, 32'hFF);
    irqIn = '0;

    // R8 soft reset
    wr(8'h00, 32'hA000_0000);
    rdReg(8'h00, rd); chk("R8 busy flag", rd, 32'h8000_0000);
    wr(8'h04, 3);
    repeat (RST_CYC + 2) @(negedge clk);
    rdReg(8'h00, rd); chk("R8 gcfg done", rd, 0);
    rdReg(8'h04, rd); chk("R8 ctp restored", rd, 15);
    rdReg(sa(3), rd); chk("R8 src masked", rd, 32'h8000_0000);
    chk("R8 irqOut", 32'(irqOut), 0);

    finishRun();
  end
endmodule